// File: doc/BRIEF.md
# Reset and Settling Fault Sequencer

This block sequences the startup of a position converter. It watches an active-low reset pin and accepts a reset only when the pin stays low for a minimum number of clock cycles. While an accepted reset is in force, it zeroes the reported position and signals loss of signal by pulling both active-low fault pins low. When the pin is released, it runs a settling timer. The length of that timer comes from the resolution code captured at the moment of release.

Fault events may arrive during settling and are held in a two-bit sticky register. Once the timer expires, the settled flag rises. The host must then read the fault register and afterwards clear it before the data-valid output rises. The fault pins always show the inverse of the sticky bits outside reset, so a host that only watches the pins also sees pending faults. The default timings assume an 8.192 MHz clock; every count is a parameter.

Top module: `reset_settle_seq`

## Requirements
- R1: A low level on `reset_req_n` is accepted as a reset only after `RST_MIN_CYC` (default 82) consecutive low samples. A shorter low pulse changes no output.
- R2: While the block is in reset, `pos_zero` is 1. It returns to 0 on the first clock edge that samples `reset_req_n` high.
- R3: While in reset, `lot_n` and `dos_n` are both 0. Outside reset, `lot_n` is the inverse of `fault_q[0]` and `dos_n` is the inverse of `fault_q[1]`.
- R4: The settling time is chosen from the `res_sel` value sampled on the edge that ends reset. Codes 00, 01, 10 and 11 select `SETTLE_C0`, `SETTLE_C1`, `SETTLE_C2` and `SETTLE_C3` cycles. `settled` rises that many clock edges after the releasing edge.
- R5: `settled` stays 1 from timer expiry until the next accepted reset, and it is never 1 while `pos_zero` is 1.
- R6: Outside reset, a 1 on `fault_evt[i]` sets `fault_q[i]`, including during settling. A bit falls only on a `clr_stb` that comes after an earlier-cycle `rd_stb`, where both happen after `settled` rose. An event in the clearing cycle wins.
- R7: `data_valid` rises on the edge of the first accepted clear after settling, and it stays 1 until the next accepted reset. A clear with no prior read, or with only reads made during settling, is ignored.
- R8: An accepted reset at any time restarts the sequence. It sets `fault_q` to 11 and drops `settled` and `data_valid`. Fault events are ignored while in reset.
- R9: Changes on `res_sel` at any time other than the releasing edge do not change the settling length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip-level asynchronous reset, active low; places the block in reset |
| reset_req_n | input | 1 | Converter reset pin, active low, pulse-width qualified |
| res_sel | input | 2 | Resolution code, sampled on release |
| fault_evt | input | 2 | Raw fault events: bit 0 tracking loss, bit 1 signal degradation |
| rd_stb | input | 1 | Host read strobe of the fault register |
| clr_stb | input | 1 | Host clear strobe of the fault register |
| pos_zero | output | 1 | Forces the position output to zero |
| lot_n | output | 1 | Tracking-loss fault pin, active low |
| dos_n | output | 1 | Signal-degradation fault pin, active low |
| settled | output | 1 | Settling timer has expired |
| data_valid | output | 1 | Faults were read and cleared after settling |
| fault_q | output | 2 | Sticky fault register value |

## Verification
The bench drives a low pulse one cycle shorter than the minimum and one exactly at the minimum. A design that is off by one in the width qualifier either resets on the short pulse or ignores the good one. It measures the settling length for all four codes and toggles `res_sel` during settling, which exposes a design that decodes the live select instead of the captured value. It also issues clears with no read, reads made only during settling, a read and clear in the same cycle, and an event that coincides with a clear. A design with a loose arming rule would raise `data_valid` too early or lose a fault.

// File: rtl/reset_settle_seq.sv
module reset_settle_seq #(
  parameter int RST_MIN_CYC = 82,
  parameter int SETTLE_C0   = 81920,
  parameter int SETTLE_C1   = 163840,
  parameter int SETTLE_C2   = 204800,
  parameter int SETTLE_C3   = 491520
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_req_n,
  input  logic [1:0] res_sel,
  input  logic [1:0] fault_evt,
  input  logic       rd_stb,
  input  logic       clr_stb,
  output logic       pos_zero,
  output logic       lot_n,
  output logic       dos_n,
  output logic       settled,
  output logic       data_valid,
  output logic [1:0] fault_q
);

  localparam int MAX01 = (SETTLE_C0 > SETTLE_C1) ? SETTLE_C0 : SETTLE_C1;
  localparam int MAX23 = (SETTLE_C2 > SETTLE_C3) ? SETTLE_C2 : SETTLE_C3;
  localparam int MAXS  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int TW    = $clog2(MAXS + 1);
  localparam int LW    = $clog2(RST_MIN_CYC + 1);

  typedef enum logic [1:0] {S_HOLD, S_SETTLE, S_WAIT, S_VALID} st_t;

  st_t           st;
  logic [LW-1:0] low;
  logic [TW-1:0] tmr, lim;
  logic [1:0]    res_q, flt;
  logic          armed;

  wire accept = !reset_req_n && (low == LW'(RST_MIN_CYC - 1));
  wire clr_ok = clr_stb && armed;
  wire done   = (st == S_WAIT) || (st == S_VALID);

  always_comb begin
    case (res_q)
      2'd0:    lim = TW'(SETTLE_C0);
      2'd1:    lim = TW'(SETTLE_C1);
      2'd2:    lim = TW'(SETTLE_C2);
      default: lim = TW'(SETTLE_C3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_HOLD;
      low   <= '0;
      tmr   <= '0;
      res_q <= '0;
      flt   <= 2'b11;
      armed <= 1'b0;
    end else begin
      if (reset_req_n)                     low <= '0;
      else if (low != LW'(RST_MIN_CYC - 1)) low <= low + 1'b1;

      if (accept) begin
        st    <= S_HOLD;
        tmr   <= '0;
        flt   <= 2'b11;
        armed <= 1'b0;
      end else begin
        case (st)
          S_HOLD: if (reset_req_n) begin
            st    <= S_SETTLE;
            res_q <= res_sel;
            tmr   <= '0;
          end
          S_SETTLE: begin
            flt <= flt | fault_evt;
            if (tmr == lim - 1'b1) st <= S_WAIT;
            else                   tmr <= tmr + 1'b1;
          end
          default: begin
            flt   <= (clr_ok ? 2'b00 : flt) | fault_evt;
            armed <= rd_stb | (armed & ~clr_stb);
            if (st == S_WAIT && clr_ok) st <= S_VALID;
          end
        endcase
      end
    end
  end

  assign pos_zero   = (st == S_HOLD);
  assign lot_n      = !pos_zero && !flt[0];
  assign dos_n      = !pos_zero && !flt[1];
  assign settled    = done;
  assign data_valid = (st == S_VALID);
  assign fault_q    = flt;

  assert_entry_needs_low_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_zero) |-> $past(!reset_req_n));

  assert_timer_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> (tmr < lim));

  assert_settled_outside_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> !pos_zero);

  assert_fault_falls_on_armed_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(fault_q) & ~fault_q)) |-> $past(clr_stb && armed && settled));

  assert_valid_after_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> ($past(clr_stb) && settled));

  assert_restart_sets_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_zero) |-> (fault_q == 2'b11 && !data_valid));

endmodule

// File: tb/tb_reset_settle_seq.sv
module tb_reset_settle_seq;
  localparam int MINC = 82;
  localparam int L0 = 50, L1 = 70, L2 = 90, L3 = 130;

  logic clk = 0, rst_n = 0, reset_req_n = 0, rd_stb = 0, clr_stb = 0;
  logic [1:0] res_sel = 0, fault_evt = 0;
  logic pos_zero, lot_n, dos_n, settled, data_valid;
  logic [1:0] fault_q;

  reset_settle_seq #(.RST_MIN_CYC(MINC), .SETTLE_C0(L0), .SETTLE_C1(L1),
                     .SETTLE_C2(L2), .SETTLE_C3(L3)) dut (
    .clk(clk), .rst_n(rst_n), .reset_req_n(reset_req_n), .res_sel(res_sel),
    .fault_evt(fault_evt), .rd_stb(rd_stb), .clr_stb(clr_stb),
    .pos_zero(pos_zero), .lot_n(lot_n), .dos_n(dos_n), .settled(settled),
    .data_valid(data_valid), .fault_q(fault_q));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference: 0 reset, 1 settling, 2 awaiting host, 3 valid
  int m_phase = 0, m_lowrun = 0, m_left = 0;
  bit [1:0] m_flt = 2'b11;
  bit m_read = 0;

  function automatic int len_of(input int code);
    int t[4] = '{L0, L1, L2, L3};
    return t[code];
  endfunction

  always @(posedge clk) begin
    bit acc;
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_lowrun = 0; m_flt = 2'b11; m_read = 0;
    end else begin
      m_lowrun = reset_req_n ? 0 : m_lowrun + 1;
      acc = (m_lowrun >= MINC);
      if (acc) begin
        m_phase = 0; m_flt = 2'b11; m_read = 0;
      end else if (m_phase == 0) begin
        if (reset_req_n) begin m_phase = 1; m_left = len_of(int'(res_sel)); end
      end else if (m_phase == 1) begin
        m_flt |= fault_evt;
        m_left--;
        if (m_left == 0) m_phase = 2;
      end else begin
        if (clr_stb && m_read) begin
          m_flt = 2'b00;
          if (m_phase == 2) m_phase = 3;
          m_read = 0;
        end else if (clr_stb) m_read = 0;
        if (rd_stb) m_read = 1;
        m_flt |= fault_evt;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    check("R2 pos_zero", pos_zero, m_phase == 0);
    check("R3 lot_n", lot_n, (m_phase != 0) && !m_flt[0]);
    check("R3 dos_n", dos_n, (m_phase != 0) && !m_flt[1]);
    check("R5 settled", settled, m_phase >= 2);
    check("R7 data_valid", data_valid, m_phase == 3);
    check("R6 fault_q", fault_q, m_flt);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit rd, input bit clr, input bit [1:0] ev);
    rd_stb = rd; clr_stb = clr; fault_evt = ev;
    @(negedge clk);
    rd_stb = 0; clr_stb = 0; fault_evt = 0;
  endtask

  task automatic restart(input int code, input int lowlen);
    int n = 0;
    reset_req_n = 0;
    idle(lowlen);
    check("R2 held in reset", pos_zero, 1);
    res_sel = 2'(code);
    reset_req_n = 1;
    res_sel = 2'(code);
    do begin @(negedge clk); n++; res_sel = 2'(3 - code); end while (!settled && n < 1000);
    check("R4/R9 settle length", n, len_of(code) + 1);
  endtask

  initial begin
    idle(3);
    check("R8 reset state faults", fault_q, 3);
    check("R3 reset pins", {lot_n, dos_n}, 0);
    rst_n = 1;
    restart(0, 100);
    check("R8 faults after settle", fault_q, 3);
    strobe(0, 1, 0);
    check("R7 clear without read ignored", data_valid, 0);
    strobe(1, 0, 0);
    strobe(0, 1, 0);
    check("R7 valid after read then clear", data_valid, 1);
    check("R6 cleared", fault_q, 0);
    strobe(0, 0, 2'b01);
    check("R3 lot_n follows bit0", lot_n, 0);
    check("R6 sticky set", fault_q, 1);
    idle(5);
    check("R6 still set", fault_q, 1);
    // short pulse ignored
    reset_req_n = 0; idle(MINC - 1); reset_req_n = 1; idle(2);
    check("R1 short pulse ignored valid", data_valid, 1);
    check("R1 short pulse ignored pos", pos_zero, 0);
    // exact minimum accepted, res 1, reads during settle do not arm
    reset_req_n = 0; idle(MINC); reset_req_n = 1; res_sel = 1;
    @(negedge clk);
    check("R1 exact minimum accepted", data_valid, 0);
    strobe(1, 0, 2'b10);
    idle(L1 + 2);
    check("R5 settled", settled, 1);
    strobe(0, 1, 0);
    check("R7 settle-time read does not arm", data_valid, 0);
    strobe(1, 1, 0);
    check("R7 read and clear same cycle", data_valid, 0);
    strobe(0, 1, 2'b10);
    check("R6 event beats clear", fault_q, 2);
    check("R7 valid", data_valid, 1);
    restart(2, MINC);
    strobe(0, 0, 2'b11);
    restart(3, 90);
    strobe(1, 0, 0);
    reset_req_n = 0; idle(MINC + 3);
    strobe(0, 0, 2'b00);
    check("R8 restart drops settled", settled, 0);
    check("R8 faults set", fault_q, 3);
    restart(1, 5);
    idle(10);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual %0d expected done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule